// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block forms operand addresses for the load/store path of a small 8-bit processor core. Three 16-bit pointers live in the top six bytes of a 32-entry byte register file. The register file delivers those six bytes to the block on one input bus. On each start strobe the block takes the requested addressing mode and pointer choice and registers a result. The result holds the effective address, the part of the unified data space that address falls in, and, where the mode changes the pointer, the new pointer value. That value is written back through the register file's byte write port.

Two further modes form program-space addresses from the third pointer: a byte address for reading constant tables, and an indirect jump target. A separate mode turns a 6-bit I/O-instruction address into its data-space address. All results appear one clock after the strobe and stay until the next strobe. The write-back enables and the valid flag last only one cycle.

Top module: `ptr_agu`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `valid_o` is 0 and `wb_we_o` is 2'b00.
- R2: Pointer selection `ptr_sel_i` is 0 for pointer A (registers 26/27), 1 for pointer B (28/29) and 2 for pointer C (30/31). Within each pair the lower-numbered register is the low byte. Byte k of `ptr_bytes_i` (bits 8k+7..8k) is register 26+k. In plain indirect mode (`mode_i`=1) the effective address equals the selected pointer.
- R3: In direct mode (`mode_i`=0), `ea_o` equals `direct_addr_i`, and no pointer is written back.
- R4: In displacement mode (`mode_i`=2), `ea_o` is the pointer plus the zero-extended 6-bit `disp_i` (0 to 63), modulo 2^16. Only pointers B and C are legal bases. Selecting A sets `illegal_o`.
- R5: In pre-decrement mode (`mode_i`=3), `ea_o` and `wb_data_o` are both the pointer minus one, modulo 2^16. `wb_we_o` is 2'b11 and `wb_idx_o` is the low register of the pair (26, 28 or 30).
- R6: In post-increment mode (`mode_i`=4), `ea_o` is the pointer before the update, and `wb_data_o` is the pointer plus one, modulo 2^16. `wb_we_o` is 2'b11 and `wb_idx_o` is the low register of the pair.
- R7: `region_o` is 1 for addresses 0x00 to 0x1F (register file), 2 for 0x20 to 0x5F (I/O) and 3 for 0x60 to 0xDF (SRAM). It is 0 when no data region applies.
- R8: Any data address above 0xDF sets `oor_o` and gives `region_o`=0.
- R9: In I/O mode (`mode_i`=5), `ea_o` is `disp_i` plus 0x20, and the region is I/O.
- R10: In constant-read mode (`mode_i`=6), the block always uses pointer C. `pm_addr_o` is bits 15..1 of pointer C, zero-extended, and `pm_hi_o` equals bit 0 of pointer C (0 selects the low byte, 1 the high byte). `prog_o` is 1, `region_o` is 0 and `oor_o` is 0.
- R11: In jump mode (`mode_i`=7), `pm_addr_o` equals pointer C and `pm_hi_o` is 0. `prog_o` is 1 and nothing is written back.
- R12: Results appear in the cycle after `start_i` is sampled high. `valid_o` and any write enable last exactly one cycle, and a cycle without a strobe writes nothing back.
- R13: `ptr_sel_i`=3 in any pointer-based data mode (1 to 4) sets `illegal_o`, with `ea_o`=0, `region_o`=0, `oor_o`=0 and `wb_we_o`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Strobe: compute one address this cycle |
| mode_i | input | 3 | Addressing mode code (0 to 7) |
| ptr_sel_i | input | 2 | Pointer choice A/B/C (3 reserved) |
| disp_i | input | 6 | Displacement, or I/O-instruction address |
| direct_addr_i | input | 16 | Address from the second instruction word |
| ptr_bytes_i | input | 48 | Register file bytes 26 to 31, lowest register in the lowest byte |
| valid_o | output | 1 | Result registered this cycle |
| ea_o | output | 16 | Effective data address |
| region_o | output | 2 | Data region code |
| oor_o | output | 1 | Data address beyond SRAM |
| illegal_o | output | 1 | Pointer choice not allowed for the mode |
| prog_o | output | 1 | Result is a program-space address |
| pm_addr_o | output | 16 | Program word address or jump target |
| pm_hi_o | output | 1 | Constant read takes the high byte |
| wb_we_o | output | 2 | Write enables for the low and high pointer bytes |
| wb_idx_o | output | 5 | Register index of the low pointer byte |
| wb_data_o | output | 16 | Updated pointer value |

## Verification
The checker assumes that `mode_i` stays steady whenever `start_i` is high, since it keeps its own copy of the mode to relate write-back data to the effective address. It also assumes that `ptr_bytes_i` reflects the register file as it was when the strobe was sampled. The bench meets both assumptions. It changes `mode_i` and `ptr_bytes_i` only on falling edges, and pulses the strobe for one cycle per operation. Pointer values are chosen on purpose at 0x0000 and 0xFFFF, and on every region boundary, so that the wrap and decode checks are exercised.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_DISP    = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_POSTINC = 3'd4,
    AM_IOREG   = 3'd5,
    AM_CONST   = 3'd6,
    AM_JUMP    = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_RFILE = 2'd1,
    RG_IO    = 2'd2,
    RG_SRAM  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    PS_A    = 2'd0,
    PS_B    = 2'd1,
    PS_C    = 2'd2,
    PS_RSVD = 2'd3
  } psel_e;
endpackage

// File: rtl/agu_ptr_pick.sv
module agu_ptr_pick #(
  parameter int BW       = 8,
  parameter int RF_DEPTH = 32,
  parameter int NPTR     = 3,
  parameter int AW       = 2 * BW,
  parameter int RIW      = $clog2(RF_DEPTH)
) (
  input  logic [2*NPTR*BW-1:0] ptr_bytes_i,
  input  logic [1:0]           sel_i,
  output logic [AW-1:0]        ptr_o,
  output logic [AW-1:0]        zptr_o,
  output logic [RIW-1:0]       idx_o,
  output logic                 sel_bad_o
);
  localparam logic [RIW-1:0] PTR_BASE = RIW'(RF_DEPTH - 2 * NPTR);

  logic [AW-1:0] ptrs [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_pair
    assign ptrs[g] = {ptr_bytes_i[(2*g+1)*BW +: BW], ptr_bytes_i[(2*g)*BW +: BW]};
  end

  assign zptr_o = ptrs[NPTR-1];

  always_comb begin
    sel_bad_o = (int'(sel_i) >= NPTR);
    ptr_o     = '0;
    idx_o     = '0;
    if (!sel_bad_o) begin
      ptr_o = ptrs[sel_i];
      idx_o = PTR_BASE + RIW'({sel_i, 1'b0});
    end
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DISP_W   = 6,
  parameter int RF_DEPTH = 32
) (
  input  logic [2:0]        mode_i,
  input  logic [1:0]        sel_i,
  input  logic              sel_bad_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic [AW-1:0]     zptr_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [AW-1:0]     direct_i,
  output logic [AW-1:0]     ea_o,
  output logic              dspace_o,
  output logic              pspace_o,
  output logic              bad_o,
  output logic [AW-1:0]     pm_addr_o,
  output logic              pm_hi_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_val_o
);
  localparam logic [AW-1:0] ONE     = AW'(1);
  localparam logic [AW-1:0] IO_BASE = AW'(RF_DEPTH);

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] ptr_dec;
  logic [AW-1:0] ptr_inc;
  logic          disp_base_ok;

  assign disp_ext     = {{(AW-DISP_W){1'b0}}, disp_i};
  assign ptr_dec      = ptr_i - ONE;
  assign ptr_inc      = ptr_i + ONE;
  assign disp_base_ok = (sel_i == PS_B) || (sel_i == PS_C);

  always_comb begin
    ea_o      = '0;
    dspace_o  = 1'b0;
    pspace_o  = 1'b0;
    bad_o     = 1'b0;
    pm_addr_o = '0;
    pm_hi_o   = 1'b0;
    wb_en_o   = 1'b0;
    wb_val_o  = '0;
    unique case (amode_e'(mode_i))
      AM_DIRECT: begin
        ea_o     = direct_i;
        dspace_o = 1'b1;
      end
      AM_IND: begin
        if (sel_bad_i) bad_o = 1'b1;
        else begin
          ea_o     = ptr_i;
          dspace_o = 1'b1;
        end
      end
      AM_DISP: begin
        if (sel_bad_i || !disp_base_ok) bad_o = 1'b1;
        else begin
          ea_o     = ptr_i + disp_ext;
          dspace_o = 1'b1;
        end
      end
      AM_PREDEC: begin
        if (sel_bad_i) bad_o = 1'b1;
        else begin
          ea_o     = ptr_dec;
          dspace_o = 1'b1;
          wb_en_o  = 1'b1;
          wb_val_o = ptr_dec;
        end
      end
      AM_POSTINC: begin
        if (sel_bad_i) bad_o = 1'b1;
        else begin
          ea_o     = ptr_i;
          dspace_o = 1'b1;
          wb_en_o  = 1'b1;
          wb_val_o = ptr_inc;
        end
      end
      AM_IOREG: begin
        ea_o     = IO_BASE + disp_ext;
        dspace_o = 1'b1;
      end
      AM_CONST: begin
        pspace_o  = 1'b1;
        pm_addr_o = {1'b0, zptr_i[AW-1:1]};
        pm_hi_o   = zptr_i[0];
      end
      default: begin
        pspace_o  = 1'b1;
        pm_addr_o = zptr_i;
      end
    endcase
  end
endmodule

// File: rtl/agu_region.sv
module agu_region
  import agu_pkg::*;
#(
  parameter int AW         = 16,
  parameter int RF_DEPTH   = 32,
  parameter int IO_DEPTH   = 64,
  parameter int SRAM_DEPTH = 128
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  output logic [1:0]    region_o,
  output logic          oor_o
);
  localparam logic [AW-1:0] RF_END = AW'(RF_DEPTH);
  localparam logic [AW-1:0] IO_END = AW'(RF_DEPTH + IO_DEPTH);
  localparam logic [AW-1:0] SR_END = AW'(RF_DEPTH + IO_DEPTH + SRAM_DEPTH);

  always_comb begin
    region_o = RG_NONE;
    oor_o    = 1'b0;
    if (en_i) begin
      if (addr_i < RF_END)      region_o = RG_RFILE;
      else if (addr_i < IO_END) region_o = RG_IO;
      else if (addr_i < SR_END) region_o = RG_SRAM;
      else                      oor_o    = 1'b1;
    end
  end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import agu_pkg::*;
#(
  parameter int BW         = 8,
  parameter int DISP_W     = 6,
  parameter int RF_DEPTH   = 32,
  parameter int IO_DEPTH   = 64,
  parameter int SRAM_DEPTH = 128,
  parameter int NPTR       = 3,
  parameter int AW         = 2 * BW,
  parameter int RIW        = $clog2(RF_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [2:0]           mode_i,
  input  logic [1:0]           ptr_sel_i,
  input  logic [DISP_W-1:0]    disp_i,
  input  logic [AW-1:0]        direct_addr_i,
  input  logic [2*NPTR*BW-1:0] ptr_bytes_i,
  output logic                 valid_o,
  output logic [AW-1:0]        ea_o,
  output logic [1:0]           region_o,
  output logic                 oor_o,
  output logic                 illegal_o,
  output logic                 prog_o,
  output logic [AW-1:0]        pm_addr_o,
  output logic                 pm_hi_o,
  output logic [1:0]           wb_we_o,
  output logic [RIW-1:0]       wb_idx_o,
  output logic [AW-1:0]        wb_data_o
);
  logic [AW-1:0]  sel_ptr;
  logic [AW-1:0]  z_ptr;
  logic [RIW-1:0] sel_idx;
  logic           sel_bad;
  logic [AW-1:0]  c_ea;
  logic           c_dspace;
  logic           c_pspace;
  logic           c_bad;
  logic [AW-1:0]  c_pm_addr;
  logic           c_pm_hi;
  logic           c_wb_en;
  logic [AW-1:0]  c_wb_val;
  logic [1:0]     c_region;
  logic           c_oor;

  agu_ptr_pick #(.BW(BW), .RF_DEPTH(RF_DEPTH), .NPTR(NPTR), .AW(AW), .RIW(RIW)) u_pick (
    .ptr_bytes_i (ptr_bytes_i),
    .sel_i       (ptr_sel_i),
    .ptr_o       (sel_ptr),
    .zptr_o      (z_ptr),
    .idx_o       (sel_idx),
    .sel_bad_o   (sel_bad)
  );

  agu_calc #(.AW(AW), .DISP_W(DISP_W), .RF_DEPTH(RF_DEPTH)) u_calc (
    .mode_i    (mode_i),
    .sel_i     (ptr_sel_i),
    .sel_bad_i (sel_bad),
    .ptr_i     (sel_ptr),
    .zptr_i    (z_ptr),
    .disp_i    (disp_i),
    .direct_i  (direct_addr_i),
    .ea_o      (c_ea),
    .dspace_o  (c_dspace),
    .pspace_o  (c_pspace),
    .bad_o     (c_bad),
    .pm_addr_o (c_pm_addr),
    .pm_hi_o   (c_pm_hi),
    .wb_en_o   (c_wb_en),
    .wb_val_o  (c_wb_val)
  );

  agu_region #(.AW(AW), .RF_DEPTH(RF_DEPTH), .IO_DEPTH(IO_DEPTH), .SRAM_DEPTH(SRAM_DEPTH)) u_region (
    .addr_i   (c_ea),
    .en_i     (c_dspace),
    .region_o (c_region),
    .oor_o    (c_oor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      ea_o      <= '0;
      region_o  <= RG_NONE;
      oor_o     <= 1'b0;
      illegal_o <= 1'b0;
      prog_o    <= 1'b0;
      pm_addr_o <= '0;
      pm_hi_o   <= 1'b0;
      wb_we_o   <= 2'b00;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else begin
      valid_o <= start_i;
      wb_we_o <= 2'b00;
      if (start_i) begin
        ea_o      <= c_ea;
        region_o  <= c_region;
        oor_o     <= c_oor;
        illegal_o <= c_bad;
        prog_o    <= c_pspace;
        pm_addr_o <= c_pm_addr;
        pm_hi_o   <= c_pm_hi;
        wb_we_o   <= {c_wb_en, c_wb_en};
        wb_idx_o  <= sel_idx;
        wb_data_o <= c_wb_val;
      end
    end
  end
endmodule

// File: rtl/ptr_agu_checker.sv
module ptr_agu_checker
  import agu_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RIW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           start_i,
  input logic [2:0]     mode_i,
  input logic           valid_o,
  input logic [AW-1:0]  ea_o,
  input logic [1:0]     region_o,
  input logic           oor_o,
  input logic           illegal_o,
  input logic           prog_o,
  input logic [1:0]     wb_we_o,
  input logic [AW-1:0]  wb_data_o
);
  logic [2:0] seen_mode;

  always_ff @(posedge clk) begin
    if (rst)          seen_mode <= '0;
    else if (start_i) seen_mode <= mode_i;
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(start_i)); // R12

  AST_WB_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    (wb_we_o != 2'b00) |-> valid_o); // R12

  AST_OOR_NO_REGION: assert property (@(posedge clk) disable iff (rst)
    oor_o |-> (region_o == RG_NONE)); // R8

  AST_PREDEC_EA_MATCHES_WB: assert property (@(posedge clk) disable iff (rst)
    (valid_o && seen_mode == AM_PREDEC && wb_we_o == 2'b11) |-> (wb_data_o == ea_o)); // R5

  AST_POSTINC_WB_AHEAD: assert property (@(posedge clk) disable iff (rst)
    (valid_o && seen_mode == AM_POSTINC && wb_we_o == 2'b11) |-> (wb_data_o == ea_o + AW'(1))); // R6

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (valid_o && illegal_o) |-> (wb_we_o == 2'b00 && region_o == RG_NONE && !oor_o)); // R13

  AST_PROG_NO_REGION: assert property (@(posedge clk) disable iff (rst)
    (valid_o && prog_o) |-> (region_o == RG_NONE && !oor_o && wb_we_o == 2'b00)); // R10

  AST_SRAM_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (valid_o && region_o == RG_SRAM) |-> (ea_o >= AW'(16'h0060) && ea_o <= AW'(16'h00DF))); // R7
endmodule

bind ptr_agu ptr_agu_checker #(.AW(AW), .RIW(RIW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .valid_o   (valid_o),
  .ea_o      (ea_o),
  .region_o  (region_o),
  .oor_o     (oor_o),
  .illegal_o (illegal_o),
  .prog_o    (prog_o),
  .wb_we_o   (wb_we_o),
  .wb_data_o (wb_data_o)
);

// File: tb/sim_ptr_agu.sv
module sim_ptr_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  ptr_sel_i = '0;
  logic [5:0]  disp_i = '0;
  logic [15:0] direct_addr_i = '0;
  logic [47:0] ptr_bytes_i = '0;
  logic        valid_o, oor_o, illegal_o, prog_o, pm_hi_o;
  logic [15:0] ea_o, pm_addr_o, wb_data_o;
  logic [1:0]  region_o, wb_we_o;
  logic [4:0]  wb_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ptr_agu u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .ptr_sel_i(ptr_sel_i),
    .disp_i(disp_i), .direct_addr_i(direct_addr_i), .ptr_bytes_i(ptr_bytes_i),
    .valid_o(valid_o), .ea_o(ea_o), .region_o(region_o), .oor_o(oor_o),
    .illegal_o(illegal_o), .prog_o(prog_o), .pm_addr_o(pm_addr_o), .pm_hi_o(pm_hi_o),
    .wb_we_o(wb_we_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_region(input logic [15:0] a);
    if (a <= 16'h001F)      return 2'd1;
    else if (a <= 16'h005F) return 2'd2;
    else if (a <= 16'h00DF) return 2'd3;
    else                    return 2'd0;
  endfunction

  task automatic set_ptrs(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    ptr_bytes_i = {c[15:8], c[7:0], b[15:8], b[7:0], a[15:8], a[7:0]};
  endtask

  task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                       input logic [15:0] da);
    @(negedge clk);
    mode_i = m; ptr_sel_i = s; disp_i = d; direct_addr_i = da; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic expect_data(input string req, input logic [15:0] ea);
    chk({req, " valid"}, valid_o, 1'b1);
    chk({req, " ea"}, ea_o, ea);
    chk({req, " region"}, region_o, exp_region(ea));
    chk({req, " oor"}, oor_o, ea > 16'h00DF);
    chk({req, " illegal"}, illegal_o, 1'b0);
    chk({req, " prog"}, prog_o, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", valid_o, 1'b0);
    chk("R1 we in reset", wb_we_o, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", valid_o, 1'b0);
    chk("R1 we after reset", wb_we_o, 2'b00);
  endtask

  task automatic t_direct();
    issue(3'd0, 2'd0, 6'd0, 16'h0075);
    expect_data("R3 direct sram", 16'h0075);
    chk("R3 no wb", wb_we_o, 2'b00);
    issue(3'd0, 2'd2, 6'd9, 16'h0005);
    expect_data("R3 direct rfile", 16'h0005);
  endtask

  task automatic t_pairs();
    set_ptrs(16'h0041, 16'h0090, 16'h1234);
    issue(3'd1, 2'd0, 6'd0, 16'h0);
    expect_data("R2 pointer A", 16'h0041);
    issue(3'd1, 2'd1, 6'd0, 16'h0);
    expect_data("R2 pointer B", 16'h0090);
    issue(3'd1, 2'd2, 6'd0, 16'h0);
    expect_data("R2 pointer C", 16'h1234);
    chk("R2 no wb", wb_we_o, 2'b00);
  endtask

  task automatic t_disp();
    set_ptrs(16'h0060, 16'h0060, 16'hFFF0);
    issue(3'd2, 2'd1, 6'd63, 16'h0);
    expect_data("R4 disp B+63", 16'h009F);
    issue(3'd2, 2'd2, 6'd32, 16'h0);
    expect_data("R4 disp C wrap", 16'h0010);
    issue(3'd2, 2'd1, 6'd0, 16'h0);
    expect_data("R4 disp B+0", 16'h0060);
    issue(3'd2, 2'd0, 6'd4, 16'h0);
    chk("R4 A base illegal", illegal_o, 1'b1);
    chk("R4 A base no region", region_o, 2'd0);
    chk("R4 A base no wb", wb_we_o, 2'b00);
  endtask

  task automatic t_predec();
    set_ptrs(16'h0080, 16'h0000, 16'h0021);
    issue(3'd3, 2'd0, 6'd0, 16'h0);
    expect_data("R5 predec A", 16'h007F);
    chk("R5 wb data", wb_data_o, 16'h007F);
    chk("R5 wb we", wb_we_o, 2'b11);
    chk("R5 wb idx", wb_idx_o, 5'd26);
    issue(3'd3, 2'd1, 6'd0, 16'h0);
    expect_data("R5 predec wrap", 16'hFFFF);
    chk("R5 wrap wb", wb_data_o, 16'hFFFF);
    chk("R5 wb idx B", wb_idx_o, 5'd28);
    @(negedge clk);
    chk("R12 we one cycle", wb_we_o, 2'b00);
    chk("R12 valid one cycle", valid_o, 1'b0);
  endtask

  task automatic t_postinc();
    set_ptrs(16'h0000, 16'h005F, 16'hFFFF);
    issue(3'd4, 2'd1, 6'd0, 16'h0);
    expect_data("R6 postinc B", 16'h005F);
    chk("R6 wb data", wb_data_o, 16'h0060);
    chk("R6 wb we", wb_we_o, 2'b11);
    chk("R6 wb idx", wb_idx_o, 5'd28);
    issue(3'd4, 2'd2, 6'd0, 16'h0);
    expect_data("R6 postinc wrap", 16'hFFFF);
    chk("R6 wrap wb", wb_data_o, 16'h0000);
    chk("R6 wb idx C", wb_idx_o, 5'd30);
  endtask

  task automatic t_regions();
    logic [15:0] pts [8] = '{16'h0000, 16'h001F, 16'h0020, 16'h005F,
                             16'h0060, 16'h00DF, 16'h00E0, 16'h8000};
    for (int i = 0; i < 8; i++) begin
      issue(3'd0, 2'd0, 6'd0, pts[i]);
      chk($sformatf("R7 region at 0x%0h", pts[i]), region_o, exp_region(pts[i]));
      chk($sformatf("R8 oor at 0x%0h", pts[i]), oor_o, pts[i] > 16'h00DF);
    end
  endtask

  task automatic t_ioreg();
    issue(3'd5, 2'd3, 6'd0, 16'hFFFF);
    expect_data("R9 io 0", 16'h0020);
    chk("R9 io region", region_o, 2'd2);
    issue(3'd5, 2'd0, 6'd63, 16'h0);
    expect_data("R9 io 63", 16'h005F);
  endtask

  task automatic t_const();
    set_ptrs(16'h1111, 16'h2222, 16'h0A55);
    issue(3'd6, 2'd0, 6'd0, 16'h0);
    chk("R10 word", pm_addr_o, 16'h052A);
    chk("R10 hi byte", pm_hi_o, 1'b1);
    chk("R10 prog", prog_o, 1'b1);
    chk("R10 region", region_o, 2'd0);
    chk("R10 oor", oor_o, 1'b0);
    set_ptrs(16'h1111, 16'h2222, 16'hFFFE);
    issue(3'd6, 2'd1, 6'd0, 16'h0);
    chk("R10 word top", pm_addr_o, 16'h7FFF);
    chk("R10 lo byte", pm_hi_o, 1'b0);
  endtask

  task automatic t_jump();
    set_ptrs(16'h0001, 16'h0002, 16'h03C7);
    issue(3'd7, 2'd0, 6'd0, 16'h0);
    chk("R11 target", pm_addr_o, 16'h03C7);
    chk("R11 hi", pm_hi_o, 1'b0);
    chk("R11 prog", prog_o, 1'b1);
    chk("R11 no wb", wb_we_o, 2'b00);
  endtask

  task automatic t_illegal();
    set_ptrs(16'h0040, 16'h0050, 16'h0060);
    for (int m = 1; m <= 4; m++) begin
      issue(3'(m), 2'd3, 6'd1, 16'h0);
      chk($sformatf("R13 mode %0d illegal", m), illegal_o, 1'b1);
      chk($sformatf("R13 mode %0d ea", m), ea_o, 16'h0);
      chk($sformatf("R13 mode %0d we", m), wb_we_o, 2'b00);
      chk($sformatf("R13 mode %0d region", m), region_o, 2'd0);
    end
  endtask

  task automatic t_nostart();
    set_ptrs(16'h0070, 16'h0070, 16'h0070);
    @(negedge clk);
    mode_i = 3'd4; ptr_sel_i = 2'd0; start_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 no strobe valid", valid_o, 1'b0);
    chk("R12 no strobe we", wb_we_o, 2'b00);
    issue(3'd4, 2'd0, 6'd0, 16'h0);
    chk("R12 one cycle latency", valid_o, 1'b1);
    chk("R12 wb after strobe", wb_data_o, 16'h0071);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_pairs();
    t_disp();
    t_predec();
    t_postinc();
    t_regions();
    t_ioreg();
    t_const();
    t_jump();
    t_illegal();
    t_nostart();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule